// File: doc/BRIEF.md
# Clock Ratio Rate Mode Detector

This block watches a frame (left/right) clock from the master-clock domain and counts how many master clocks fit into one frame period. The measured count is checked against the set of ratios the converter supports, and each supported ratio is mapped to one of two oversampling modes. Base rate suits frame rates up to about 50 kHz. High rate suits frame rates up to about 100 kHz. A divide-by-two control bit, taken from a configuration register, doubles every accepted ratio. Downstream logic uses this to accept a master clock that runs at twice the usual rate.

The frame clock passes through a two-flop synchronizer and a rising-edge detector. A counter measures the distance between successive rising edges. A result is published only when two consecutive frames measure the same count. Counts outside the accepted set, and a frame clock that has stopped, raise an error. The block has no data stream: all of its pins are plain control and status levels, so no valid/ready handshake and no back-pressure apply.

Top module: `clk_ratio_mode_detect`

## Requirements
- R1: While reset is asserted and after it is released, `mode_o`, `ratio_o`, `valid_o` and `error_o` all read 0 until a measurement has been confirmed or has failed.
- R2: With `div2_i` = 0, confirmed counts of 256, 384 and 512 give `mode_o` = 0 (base rate), and counts of 128 and 192 give `mode_o` = 1 (high rate).
- R3: With `div2_i` = 1, confirmed counts of 512, 768 and 1024 give `mode_o` = 0, and counts of 256 and 384 give `mode_o` = 1.
- R4: `valid_o` asserts, and `mode_o`/`ratio_o` take a new value, only after two consecutive frame periods measure the same supported count. A measurement that differs from the one before it clears `valid_o` and leaves `mode_o` unchanged.
- R5: While `valid_o` = 1, `ratio_o` equals the confirmed number of master clocks per frame period.
- R6: A completed measurement outside the accepted set for the current `div2_i` sets `error_o` = 1 and `valid_o` = 0. `error_o` returns to 0 when a new count is confirmed.
- R7: A change of `div2_i` clears `valid_o` on the next master clock edge and discards the measurement in progress. A new result needs three further rising frame edges.
- R8: The period counter saturates at 2047 and does not wrap. If no rising frame edge arrives for 2047 master clocks, `error_o` = 1 and `valid_o` = 0.
- R9: Outputs react to a rising frame edge on the third master clock edge after the frame clock goes high at the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; all logic runs on its rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| frame_clk_i | input | 1 | Frame (left/right) clock, asynchronous to clk_i |
| div2_i | input | 1 | Configuration bit; 1 doubles the accepted ratios |
| mode_o | output | 1 | Confirmed oversampling mode: 0 base rate, 1 high rate |
| ratio_o | output | 11 | Confirmed master clocks per frame period |
| valid_o | output | 1 | Confirmed result present on mode_o and ratio_o |
| error_o | output | 1 | Unsupported ratio or stopped frame clock |

## Verification
A rising frame edge reaches the outputs three master clocks after it appears at the input: two synchronizer flops, then the registered decision. The bench drives every frame edge on a falling clock edge and samples on falling edges. It probes one edge two samples after the input rise, where the old value must still show, and again one sample later, where the new value must show. A change of the divide bit is due one clock later, and a stall error is due 2047 clocks after the last edge. The bench samples these only after the due cycle has passed. Steady-state results are checked at the end of the fourth frame of each vector, which is well past the three-edge confirmation point.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

  typedef enum logic {
    MODE_BASE = 1'b0,
    MODE_HIGH = 1'b1
  } rate_mode_e;

  localparam int unsigned NUM_RATIOS = 5;
  localparam int unsigned NUM_HIGH   = 2;

  // Accepted ratios as multiples of a unit; the first NUM_HIGH entries are high rate.
  function automatic int unsigned ratio_of(input int unsigned idx, input int unsigned unit);
    case (idx)
      0:       ratio_of = 2 * unit;
      1:       ratio_of = 3 * unit;
      2:       ratio_of = 4 * unit;
      3:       ratio_of = 6 * unit;
      default: ratio_of = 8 * unit;
    endcase
  endfunction

endpackage

// File: rtl/frame_edge_sync.sv
module frame_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

  assert_rise_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ratio_period_counter.sv
module ratio_period_counter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             rise_i,
  output logic             meas_o,
  output logic [CNT_W-1:0] count_o,
  output logic             stall_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || restart_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (rise_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stall_o = (cnt_q == CNT_MAX);
  assign meas_o  = rise_i & armed_q & ~restart_i;
  assign count_o = stall_o ? CNT_MAX : cnt_q + 1'b1;

  assert_cnt_saturates_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !rise_i && !restart_i) |=> stall_o);
  assert_meas_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_o |-> (count_o != '0));
endmodule

// File: rtl/ratio_classify.sv
module ratio_classify
  import clk_ratio_pkg::*;
#(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned UNIT  = 64
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic             div2_i,
  output logic             ok_o,
  output rate_mode_e       mode_o
);
  logic [CNT_W-1:0]      norm;
  logic                  odd_bad;
  logic [NUM_RATIOS-1:0] hit;
  logic [NUM_RATIOS-1:0] hit_high;

  assign norm    = div2_i ? (count_i >> 1) : count_i;
  assign odd_bad = div2_i & count_i[0];

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_ratio
    localparam int unsigned RVAL = ratio_of(g, UNIT);
    assign hit[g] = !odd_bad && (norm == CNT_W'(RVAL));
    if (g < NUM_HIGH) begin : g_high
      assign hit_high[g] = hit[g];
    end else begin : g_base
      assign hit_high[g] = 1'b0;
    end
  end

  assign ok_o   = |hit;
  assign mode_o = (|hit_high) ? MODE_HIGH : MODE_BASE;

  always_comb begin
    assert_one_ratio_R2: assert ($countones(hit) <= 1);
  end
endmodule

// File: rtl/clk_ratio_mode_detect.sv
module clk_ratio_mode_detect
  import clk_ratio_pkg::*;
#(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned UNIT  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_clk_i,
  input  logic             div2_i,
  output logic             mode_o,
  output logic [CNT_W-1:0] ratio_o,
  output logic             valid_o,
  output logic             error_o
);
  logic             rise;
  logic             meas;
  logic             stall;
  logic             restart;
  logic [CNT_W-1:0] count;
  logic             cls_ok;
  rate_mode_e       cls_mode;

  logic             div_q;
  logic [CNT_W-1:0] prev_q;
  logic             prev_ok_q;
  rate_mode_e       mode_q;
  logic [CNT_W-1:0] ratio_q;
  logic             valid_q;
  logic             error_q;

  frame_edge_sync u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (frame_clk_i),
    .rise_o  (rise)
  );

  ratio_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .rise_i    (rise),
    .meas_o    (meas),
    .count_o   (count),
    .stall_o   (stall)
  );

  ratio_classify #(.CNT_W(CNT_W), .UNIT(UNIT)) u_cls (
    .count_i (count),
    .div2_i  (div_q),
    .ok_o    (cls_ok),
    .mode_o  (cls_mode)
  );

  assign restart = (div2_i != div_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      div_q     <= 1'b0;
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
      mode_q    <= MODE_BASE;
      ratio_q   <= '0;
      valid_q   <= 1'b0;
      error_q   <= 1'b0;
    end else if (restart) begin
      div_q     <= div2_i;
      prev_ok_q <= 1'b0;
      valid_q   <= 1'b0;
    end else if (meas && !cls_ok) begin
      error_q   <= 1'b1;
      valid_q   <= 1'b0;
      prev_ok_q <= 1'b0;
    end else if (meas) begin
      if (prev_ok_q && (count == prev_q)) begin
        valid_q <= 1'b1;
        error_q <= 1'b0;
        mode_q  <= cls_mode;
        ratio_q <= count;
      end else begin
        valid_q   <= 1'b0;
        prev_q    <= count;
        prev_ok_q <= 1'b1;
      end
    end else if (stall) begin
      error_q   <= 1'b1;
      valid_q   <= 1'b0;
      prev_ok_q <= 1'b0;
    end
  end

  assign mode_o  = mode_q;
  assign ratio_o = ratio_q;
  assign valid_o = valid_q;
  assign error_o = error_q;

  assert_valid_error_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && error_o));
  assert_mode_on_confirm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> valid_o);
  assert_div_clears_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div2_i != div_q) |=> !valid_o);
  assert_stall_error_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall && !rise && !restart) |=> error_o);
  assert_ratio_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !meas) |=> (valid_o == 1'b0 || $stable(ratio_o)));
endmodule

// File: tb/clk_ratio_mode_detect_bench.sv
module clk_ratio_mode_detect_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame = 1'b0;
  logic        div2 = 1'b0;
  logic        mode;
  logic [10:0] ratio;
  logic        valid;
  logic        error;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  clk_ratio_mode_detect u_clk_ratio_mode_detect (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .frame_clk_i (frame),
    .div2_i      (div2),
    .mode_o      (mode),
    .ratio_o     (ratio),
    .valid_o     (valid),
    .error_o     (error)
  );

  typedef struct packed {
    bit [11:0] p;
    bit        div;
    bit        v;
    bit        m;
    bit        e;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{12'd256,  1'b0, 1'b1, 1'b0, 1'b0},
    '{12'd384,  1'b0, 1'b1, 1'b0, 1'b0},
    '{12'd512,  1'b0, 1'b1, 1'b0, 1'b0},
    '{12'd128,  1'b0, 1'b1, 1'b1, 1'b0},
    '{12'd192,  1'b0, 1'b1, 1'b1, 1'b0},
    '{12'd768,  1'b0, 1'b0, 1'b0, 1'b1},
    '{12'd1024, 1'b0, 1'b0, 1'b0, 1'b1},
    '{12'd300,  1'b0, 1'b0, 1'b0, 1'b1},
    '{12'd512,  1'b1, 1'b1, 1'b0, 1'b0},
    '{12'd768,  1'b1, 1'b1, 1'b0, 1'b0},
    '{12'd1024, 1'b1, 1'b1, 1'b0, 1'b0},
    '{12'd256,  1'b1, 1'b1, 1'b1, 1'b0},
    '{12'd384,  1'b1, 1'b1, 1'b1, 1'b0},
    '{12'd128,  1'b1, 1'b0, 1'b0, 1'b1},
    '{12'd192,  1'b1, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // One frame of p master clocks; starts and ends on a falling edge.
  task automatic run_frame(input int p);
    frame = 1'b1;
    repeat (p / 2) @(negedge clk);
    frame = 1'b0;
    repeat (p - p / 2) @(negedge clk);
  endtask

  task automatic run_frames(input int p, input int n);
    for (int i = 0; i < n; i++) run_frame(p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(valid), 0);
    check("R1 error in reset", int'(error), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mode after reset", int'(mode), 0);
    check("R1 ratio after reset", int'(ratio), 0);
    check("R1 valid after reset", int'(valid), 0);

    // R4 / R9: confirmation on the third edge, due three clocks after it
    run_frames(256, 2);
    check("R4 valid after one measurement", int'(valid), 0);
    frame = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 valid two clocks after edge", int'(valid), 0);
    @(negedge clk);
    check("R9 valid three clocks after edge", int'(valid), 1);
    check("R5 ratio 256", int'(ratio), 256);
    repeat (128 - 3) @(negedge clk);
    frame = 1'b0;
    repeat (128) @(negedge clk);

    // R4: a differing measurement drops valid and holds mode
    run_frames(128, 2);
    check("R4 valid drops on change", int'(valid), 0);
    check("R4 mode held", int'(mode), 0);
    check("R4 ratio held", int'(ratio), 256);
    run_frame(128);
    check("R4 valid after repeat", int'(valid), 1);
    check("R4 mode high", int'(mode), 1);

    // Table walk: R2 (div clear), R3 (div set), R6 (unsupported)
    for (int k = 0; k < NV; k++) begin
      div2 = VECS[k].div;
      @(negedge clk);
      run_frames(int'(VECS[k].p), 4);
      if (VECS[k].div == 1'b0) begin
        check("R2 valid", int'(valid), int'(VECS[k].v));
        if (VECS[k].v) check("R2 mode", int'(mode), int'(VECS[k].m));
      end else begin
        check("R3 valid", int'(valid), int'(VECS[k].v));
        if (VECS[k].v) check("R3 mode", int'(mode), int'(VECS[k].m));
      end
      check("R6 error", int'(error), int'(VECS[k].e));
      if (VECS[k].v) check("R5 ratio", int'(ratio), int'(VECS[k].p));
    end

    // R7: divide bit change restarts measurement
    div2 = 1'b0;
    @(negedge clk);
    run_frames(512, 4);
    check("R7 valid before toggle", int'(valid), 1);
    div2 = 1'b1;
    @(negedge clk);
    check("R7 valid cleared", int'(valid), 0);
    run_frames(512, 2);
    check("R7 valid after two edges", int'(valid), 0);
    run_frame(512);
    check("R7 valid after three edges", int'(valid), 1);
    check("R7 mode base", int'(mode), 0);

    // R8: stopped frame clock
    repeat (2100) @(negedge clk);
    check("R8 error on stall", int'(error), 1);
    check("R8 valid on stall", int'(valid), 0);
    run_frames(2500, 2);
    check("R8 long period error", int'(error), 1);
    run_frames(512, 3);
    check("R6 error clears", int'(error), 0);
    check("R6 valid returns", int'(valid), 1);
    check("R5 ratio 512", int'(ratio), 512);

    finish_run();
  end
endmodule